// File: doc/BRIEF.md
# Inverter start-up sequencer

This block sits on the controller side of a three-phase inverter module whose high-side gate drivers run from bootstrap capacitors. After power-up those capacitors are empty and the module's short-circuit fault latch may be set. The block takes the seven gate-command lines through a fixed power-up routine before ordinary modulation starts. The lines are three upper-arm inputs, three lower-arm inputs and one brake input, and all of them are active low.

A start request begins the routine. First the block switches on all three lower arms together for a train of short pulses, which charges the bootstrap capacitors. The pulse count is set by an input and clamped to a fixed legal range. Next it issues single on-pulses in a fixed order: the brake first, then the lower group, then the upper group. Off gaps separate the groups. This order clears the module's latched fault.

The block then samples the module's fault line. If the line is clear, the block raises a done flag and from then on passes the external PWM commands straight to the module. If the line is still active, the block raises an error flag, holds every line off and never releases PWM. The fault line is not examined before that final decision, so a fault indication during charging does not stop the routine. Pulse widths and gaps are parameters counted in clock cycles.

Top module: `inv_startup_seq`

## Requirements
- R1: After reset, and while idle, every gate line is high (off), seq_done and seq_error are low, and the PWM command inputs have no effect on the gate lines.
- R2: One clock edge after start_req is sampled high in idle, the three gate_lo_n lines go low together for ON_CYC cycles and then go high for OFF_CYC cycles. This repeats once per charging pulse. gate_up_n and gate_brk_n stay high throughout charging.
- R3: The number of charging pulses equals pulse_count clamped to the range 10..500. A value below 10 gives 10 pulses and a value above 500 gives 500 pulses.
- R4: After the last charging off-time, gate_brk_n is low for RST_ON_CYC cycles, then all lines are high for GAP_CYC cycles. The three gate_lo_n lines are then low for RST_ON_CYC cycles, followed by GAP_CYC off cycles. Finally the three gate_up_n lines are low for RST_ON_CYC cycles, followed by GAP_CYC off cycles. Only one group is low at any time.
- R5: A low level on fault_n during charging or during the reset pulses does not alter or abort the sequence.
- R6: At the end of the last gap, if fault_n is high, seq_done rises and stays high. In that state each gate line equals its PWM command input (bit i of each 3-bit bus is phase i). If fault_n is low instead, seq_error rises and stays high, every gate line stays high, and seq_done stays low.
- R7: start_req has no effect while the sequence runs and after it has finished.
- R8: A synchronous reset at any point returns the block to idle. From the next cycle every gate line is high and both flags are low.
- R9: Until seq_done rises, the upper and lower lines of a phase are never low together. The sequencer also keeps at least GAP_CYC all-off cycles between the last lower on-cycle and the first upper on-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Begins the start-up routine when sampled high in idle |
| pulse_count | input | 10 | Requested number of charging pulses, clamped to 10..500 |
| fault_n | input | 1 | Module fault line, low means fault, synchronised externally |
| pwm_up_n | input | 3 | External upper-arm commands, active low |
| pwm_lo_n | input | 3 | External lower-arm commands, active low |
| pwm_brk_n | input | 1 | External brake command, active low |
| gate_up_n | output | 3 | Upper-arm module inputs, active low |
| gate_lo_n | output | 3 | Lower-arm module inputs, active low |
| gate_brk_n | output | 1 | Brake module input, active low |
| seq_done | output | 1 | Sequence finished cleanly, PWM passed through |
| seq_error | output | 1 | Fault still present after the reset pulses |

## Verification
The hardest case to reach is the one where the fault line is active during the start-up routine and then either clears or stays active exactly at the end of the final gap. A single cycle at that point decides between pass-through and lock-out. The bench drives fault_n low from the first charging pulse in several table entries. In some entries it releases the line right after charging, and in others it holds the line low to the end. The full seven-line pattern is compared against a cycle-indexed model throughout, so an early abort or a shifted decision shows up as a pattern mismatch. Each run also pulses start_req in the middle of charging, which exercises the rule that a second request is ignored. The clamp limits are covered by counts of 0, 3, 499 and 600.

// File: rtl/isq_pkg.sv
package isq_pkg;

    // Width of the pulse-count setting and its legal limits
    localparam int unsigned COUNT_W = 10;
    localparam logic [COUNT_W-1:0] PULSES_LO = 10'd10;
    localparam logic [COUNT_W-1:0] PULSES_HI = 10'd500;

    // Phases of the power-up routine
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHG_ON,
        ST_CHG_OFF,
        ST_BRK_ON,
        ST_BRK_GAP,
        ST_LO_ON,
        ST_LO_GAP,
        ST_UP_ON,
        ST_UP_GAP,
        ST_DONE,
        ST_ERR
    } isq_state_e;

    // The seven active-low module inputs, carried as one word
    typedef struct packed {
        logic       brk_n;
        logic [2:0] lo_n;
        logic [2:0] up_n;
    } gate_set_t;

    localparam gate_set_t GATES_OFF = '{brk_n: 1'b1, lo_n: 3'b111, up_n: 3'b111};

    // Clamp a requested pulse count into the legal range
    function automatic logic [COUNT_W-1:0] clamp_count(input logic [COUNT_W-1:0] raw);
        if (raw < PULSES_LO)
            return PULSES_LO;
        else if (raw > PULSES_HI)
            return PULSES_HI;
        else
            return raw;
    endfunction

    // Largest of four durations, used to size the step timer
    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/isq_step_timer.sv
// Down-counter that times the current phase. A load with D-1 gives a phase of D cycles.
module isq_step_timer #(
    parameter int unsigned TMR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    logic [TMR_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - TMR_W'(1);
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/isq_pulse_ctr.sv
// Counts the charging pulses still to be issued.
module isq_pulse_ctr
    import isq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [COUNT_W-1:0] req_count,
    input  logic               dec,
    output logic               last
);
    logic [COUNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= clamp_count(req_count);
        else if (dec && left != '0)
            left <= left - COUNT_W'(1);
    end

    // The pulse now ending is the final one
    assign last = (left <= COUNT_W'(1));
endmodule

// File: rtl/isq_fsm.sv
// Phase controller: steps through charging, ordered reset pulses and the final decision.
module isq_fsm
    import isq_pkg::*;
#(
    parameter int unsigned ON_CYC     = 2000,
    parameter int unsigned OFF_CYC    = 2000,
    parameter int unsigned RST_ON_CYC = 2000,
    parameter int unsigned GAP_CYC    = 220,
    parameter int unsigned TMR_W      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             fault_n,
    input  logic             tmr_expired,
    input  logic             last_pulse,
    output isq_state_e       state,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             pulse_load,
    output logic             pulse_dec
);
    localparam logic [TMR_W-1:0] ON_LD  = TMR_W'(ON_CYC - 1);
    localparam logic [TMR_W-1:0] OFF_LD = TMR_W'(OFF_CYC - 1);
    localparam logic [TMR_W-1:0] RST_LD = TMR_W'(RST_ON_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LD = TMR_W'(GAP_CYC - 1);

    isq_state_e next_state;

    always_comb begin
        next_state = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        pulse_load = 1'b0;
        pulse_dec  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start_req) begin
                    next_state = ST_CHG_ON;
                    tmr_load   = 1'b1;
                    tmr_val    = ON_LD;
                    pulse_load = 1'b1;
                end
            end
            ST_CHG_ON: begin
                if (tmr_expired) begin
                    next_state = ST_CHG_OFF;
                    tmr_load   = 1'b1;
                    tmr_val    = OFF_LD;
                end
            end
            ST_CHG_OFF: begin
                if (tmr_expired) begin
                    pulse_dec = 1'b1;
                    tmr_load  = 1'b1;
                    if (last_pulse) begin
                        next_state = ST_BRK_ON;
                        tmr_val    = RST_LD;
                    end else begin
                        next_state = ST_CHG_ON;
                        tmr_val    = ON_LD;
                    end
                end
            end
            ST_BRK_ON: begin
                if (tmr_expired) begin
                    next_state = ST_BRK_GAP;
                    tmr_load   = 1'b1;
                    tmr_val    = GAP_LD;
                end
            end
            ST_BRK_GAP: begin
                if (tmr_expired) begin
                    next_state = ST_LO_ON;
                    tmr_load   = 1'b1;
                    tmr_val    = RST_LD;
                end
            end
            ST_LO_ON: begin
                if (tmr_expired) begin
                    next_state = ST_LO_GAP;
                    tmr_load   = 1'b1;
                    tmr_val    = GAP_LD;
                end
            end
            ST_LO_GAP: begin
                if (tmr_expired) begin
                    next_state = ST_UP_ON;
                    tmr_load   = 1'b1;
                    tmr_val    = RST_LD;
                end
            end
            ST_UP_ON: begin
                if (tmr_expired) begin
                    next_state = ST_UP_GAP;
                    tmr_load   = 1'b1;
                    tmr_val    = GAP_LD;
                end
            end
            ST_UP_GAP: begin
                // The only point where the fault line is consulted
                if (tmr_expired)
                    next_state = fault_n ? ST_DONE : ST_ERR;
            end
            ST_DONE:  next_state = ST_DONE;
            ST_ERR:   next_state = ST_ERR;
            default:  next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= next_state;
    end
endmodule

// File: rtl/isq_gate_mux.sv
// Chooses the seven gate lines from the phase, or passes PWM through once finished.
module isq_gate_mux
    import isq_pkg::*;
(
    input  isq_state_e state,
    input  gate_set_t  pwm_cmd,
    output gate_set_t  gates,
    output logic       done,
    output logic       error
);
    always_comb begin
        gates = GATES_OFF;
        case (state)
            ST_CHG_ON: gates.lo_n  = 3'b000;
            ST_BRK_ON: gates.brk_n = 1'b0;
            ST_LO_ON:  gates.lo_n  = 3'b000;
            ST_UP_ON:  gates.up_n  = 3'b000;
            ST_DONE:   gates       = pwm_cmd;
            default:   gates       = GATES_OFF;
        endcase
    end

    assign done  = (state == ST_DONE);
    assign error = (state == ST_ERR);
endmodule

// File: rtl/inv_startup_seq.sv
// Top level of the inverter start-up sequencer.
module inv_startup_seq
    import isq_pkg::*;
#(
    parameter int unsigned ON_CYC     = 2000,
    parameter int unsigned OFF_CYC    = ON_CYC,
    parameter int unsigned RST_ON_CYC = 2000,
    parameter int unsigned GAP_CYC    = 220
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic [COUNT_W-1:0] pulse_count,
    input  logic               fault_n,
    input  logic [2:0]         pwm_up_n,
    input  logic [2:0]         pwm_lo_n,
    input  logic               pwm_brk_n,
    output logic [2:0]         gate_up_n,
    output logic [2:0]         gate_lo_n,
    output logic               gate_brk_n,
    output logic               seq_done,
    output logic               seq_error
);
    localparam int unsigned LONGEST = max_of4(ON_CYC, OFF_CYC, RST_ON_CYC, GAP_CYC);
    localparam int unsigned TMR_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

    isq_state_e       state;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             pulse_load;
    logic             pulse_dec;
    logic             last_pulse;
    gate_set_t        pwm_cmd;
    gate_set_t        gates;

    isq_fsm #(
        .ON_CYC     (ON_CYC),
        .OFF_CYC    (OFF_CYC),
        .RST_ON_CYC (RST_ON_CYC),
        .GAP_CYC    (GAP_CYC),
        .TMR_W      (TMR_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .fault_n     (fault_n),
        .tmr_expired (tmr_expired),
        .last_pulse  (last_pulse),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .pulse_load  (pulse_load),
        .pulse_dec   (pulse_dec)
    );

    isq_step_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    isq_pulse_ctr u_pulses (
        .clk       (clk),
        .rst       (rst),
        .load      (pulse_load),
        .req_count (pulse_count),
        .dec       (pulse_dec),
        .last      (last_pulse)
    );

    assign pwm_cmd = '{brk_n: pwm_brk_n, lo_n: pwm_lo_n, up_n: pwm_up_n};

    isq_gate_mux u_mux (
        .state   (state),
        .pwm_cmd (pwm_cmd),
        .gates   (gates),
        .done    (seq_done),
        .error   (seq_error)
    );

    assign gate_up_n  = gates.up_n;
    assign gate_lo_n  = gates.lo_n;
    assign gate_brk_n = gates.brk_n;
endmodule

// File: rtl/isq_checker.sv
// Property checker attached to the sequencer top level.
module isq_checker #(
    parameter int unsigned GAP_CYC = 220
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] pwm_up_n,
    input logic [2:0] pwm_lo_n,
    input logic       pwm_brk_n,
    input logic [2:0] gate_up_n,
    input logic [2:0] gate_lo_n,
    input logic       gate_brk_n,
    input logic       seq_done,
    input logic       seq_error
);
    localparam int unsigned RUN_W = $clog2(GAP_CYC + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_SAT = '1;

    // Number of cycles since a lower arm was last on (saturating)
    logic [RUN_W-1:0] lo_off_run;

    always_ff @(posedge clk) begin
        if (rst)
            lo_off_run <= RUN_SAT;
        else if (gate_lo_n != 3'b111)
            lo_off_run <= '0;
        else if (lo_off_run != RUN_SAT)
            lo_off_run <= lo_off_run + RUN_W'(1);
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gate_up_n == 3'b111 && gate_lo_n == 3'b111 && gate_brk_n && !seq_done && !seq_error)); // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(seq_done && seq_error)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> seq_done); // R6

    AST_ERR_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        seq_error |-> (gate_up_n == 3'b111 && gate_lo_n == 3'b111 && gate_brk_n)); // R6

    AST_DONE_PASS: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (gate_up_n == pwm_up_n && gate_lo_n == pwm_lo_n && gate_brk_n == pwm_brk_n)); // R6

    AST_BRK_ALONE: assert property (@(posedge clk) disable iff (rst)
        (!seq_done && !gate_brk_n) |-> (gate_up_n == 3'b111 && gate_lo_n == 3'b111)); // R4

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        !seq_done |-> ((~gate_up_n & ~gate_lo_n) == 3'b000)); // R9

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        (!seq_done && gate_up_n != 3'b111 && $past(gate_up_n) == 3'b111)
            |-> (lo_off_run >= RUN_W'(GAP_CYC))); // R9
endmodule

bind inv_startup_seq isq_checker #(.GAP_CYC(GAP_CYC)) u_isq_chk (
    .clk        (clk),
    .rst        (rst),
    .pwm_up_n   (pwm_up_n),
    .pwm_lo_n   (pwm_lo_n),
    .pwm_brk_n  (pwm_brk_n),
    .gate_up_n  (gate_up_n),
    .gate_lo_n  (gate_lo_n),
    .gate_brk_n (gate_brk_n),
    .seq_done   (seq_done),
    .seq_error  (seq_error)
);

// File: tb/inv_startup_seq_test.sv
module inv_startup_seq_test;

    localparam int ON  = 4;
    localparam int OFF = 3;
    localparam int RON = 5;
    localparam int GAP = 2;
    localparam int PER = ON + OFF;
    localparam int TAIL = 3 * (RON + GAP);

    localparam logic [6:0] ALL_OFF = 7'b1111111;
    localparam logic [6:0] LO_ON   = 7'b1000111;
    localparam logic [6:0] UP_ON   = 7'b1111000;
    localparam logic [6:0] BRK_ON  = 7'b0111111;

    // Fault modes: 0 never active, 1 active during charging only, 2 active to the end
    typedef struct packed {
        logic [9:0] cnt_in;
        logic [9:0] eff;
        logic [1:0] fmode;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{10'd10,  10'd10,  2'd0},
        '{10'd3,   10'd10,  2'd1},
        '{10'd600, 10'd500, 2'd0},
        '{10'd11,  10'd11,  2'd2},
        '{10'd0,   10'd10,  2'd2},
        '{10'd499, 10'd499, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [9:0] pulse_count = 10'd10;
    logic       fault_n = 1'b1;
    logic [2:0] pwm_up_n = 3'b111;
    logic [2:0] pwm_lo_n = 3'b111;
    logic       pwm_brk_n = 1'b1;
    logic [2:0] gate_up_n;
    logic [2:0] gate_lo_n;
    logic       gate_brk_n;
    logic       seq_done;
    logic       seq_error;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    inv_startup_seq #(
        .ON_CYC(ON), .OFF_CYC(OFF), .RST_ON_CYC(RON), .GAP_CYC(GAP)
    ) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .pulse_count(pulse_count),
        .fault_n(fault_n), .pwm_up_n(pwm_up_n), .pwm_lo_n(pwm_lo_n), .pwm_brk_n(pwm_brk_n),
        .gate_up_n(gate_up_n), .gate_lo_n(gate_lo_n), .gate_brk_n(gate_brk_n),
        .seq_done(seq_done), .seq_error(seq_error)
    );

    function automatic logic [6:0] gates_now();
        return {gate_brk_n, gate_lo_n, gate_up_n};
    endfunction

    // Expected line pattern t cycles after the start request was sampled
    function automatic logic [6:0] expect_at(int t, int n);
        int u;
        if (t < n * PER)
            return ((t % PER) < ON) ? LO_ON : ALL_OFF;
        u = t - n * PER;
        if (u < RON)               return BRK_ON;
        if (u < RON + GAP)         return ALL_OFF;
        if (u < 2 * RON + GAP)     return LO_ON;
        if (u < 2 * RON + 2 * GAP) return ALL_OFF;
        if (u < 3 * RON + 2 * GAP) return UP_ON;
        return ALL_OFF;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start_req = 1'b0;
        fault_n = 1'b1;
        pwm_up_n = 3'b111; pwm_lo_n = 3'b111; pwm_brk_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vector(input vec_t v);
        int n;
        int last_t;
        int bad;
        logic [6:0] bad_act;
        logic [6:0] bad_exp;
        logic [6:0] pat;
        n = int'(v.eff);
        last_t = n * PER + TAIL;
        bad = 0;
        bad_act = '0;
        bad_exp = '0;
        do_reset();
        @(negedge clk);
        pulse_count = v.cnt_in;
        start_req = 1'b1;
        if (v.fmode != 2'd0) fault_n = 1'b0;
        for (int t = 0; t < last_t; t++) begin
            @(negedge clk);
            if (gates_now() !== expect_at(t, n) || seq_done || seq_error) begin
                if (bad == 0) begin
                    bad_act = gates_now();
                    bad_exp = expect_at(t, n);
                end
                bad++;
            end
            start_req = (t == 20);          // second request mid-charge, must be ignored
            if (v.fmode == 2'd1 && t == n * PER) fault_n = 1'b1;
        end
        // R2 R3 R4 R5 R7: whole-pattern comparison
        check(bad == 0, "R2/R3/R4/R5/R7 sequence pattern", 32'(bad_act), 32'(bad_exp));
        @(negedge clk);
        if (v.fmode == 2'd2)
            check(seq_error && !seq_done && gates_now() == ALL_OFF, "R6 error lockout",
                  {seq_done, seq_error, gates_now()}, {2'b01, ALL_OFF});
        else
            check(seq_done && !seq_error, "R5/R6 done flag",
                  {seq_done, seq_error}, 2'b10);
        pat = 7'b0101010;
        {pwm_brk_n, pwm_lo_n, pwm_up_n} = pat;
        start_req = 1'b1;
        #1;
        check(gates_now() == ((v.fmode == 2'd2) ? ALL_OFF : pat), "R6/R7 output after sequence",
              32'(gates_now()), 32'((v.fmode == 2'd2) ? ALL_OFF : pat));
        start_req = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        @(negedge clk);
        check(gates_now() == ALL_OFF && !seq_done && !seq_error, "R1 reset state",
              {seq_done, seq_error, gates_now()}, {2'b00, ALL_OFF});
        // R1 PWM ignored in idle
        pwm_up_n = 3'b000; pwm_lo_n = 3'b010; pwm_brk_n = 1'b0;
        @(negedge clk);
        check(gates_now() == ALL_OFF && !seq_done, "R1 idle ignores pwm",
              32'(gates_now()), 32'(ALL_OFF));
        pwm_up_n = 3'b111; pwm_lo_n = 3'b111; pwm_brk_n = 1'b1;

        for (int i = 0; i < NVEC; i++)
            run_vector(VEC[i]);

        // R8 synchronous reset in the middle of charging
        do_reset();
        @(negedge clk);
        pulse_count = 10'd10;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(gates_now() == LO_ON, "R2 first charge pulse", 32'(gates_now()), 32'(LO_ON));
        repeat (25) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(gates_now() == ALL_OFF && !seq_done && !seq_error, "R8 reset mid-sequence",
              {seq_done, seq_error, gates_now()}, {2'b00, ALL_OFF});
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(gates_now() == ALL_OFF, "R8 stays idle after reset", 32'(gates_now()), 32'(ALL_OFF));
        // R7 a fresh start is accepted again from idle
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(gates_now() == LO_ON, "R7 start accepted from idle", 32'(gates_now()), 32'(LO_ON));
        // R9 no phase has both arms on before done (sampled over the rest of this run)
        begin
            int clash = 0;
            for (int t = 1; t < 10 * PER + TAIL; t++) begin
                @(negedge clk);
                if (((~gate_up_n) & (~gate_lo_n)) != 3'b000) clash++;
            end
            check(clash == 0, "R9 no shoot-through", 32'(clash), 32'd0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule